// File: doc/BRIEF.md
# Crosspoint Switch Configuration Register

This block holds the routing configuration of an eight-output, eight-input digital crosspoint and performs the routing. A host loads a new configuration into a shadow register and then copies it to a set of transparent update latches that drive the selection datapath. Each output has a three-bit source select and an enable bit. A disabled output drives 0 and raises its idle flag.

There are two ways to load the shadow register. In serial mode a whole 32-bit frame is shifted in on falling clock edges. The far end of the shift chain appears on a serial output pin, so several devices can share one chain. In parallel mode a single output's entry is written in one falling edge, and the other entries are left alone. A chip-enable gates both paths.

The copy from shadow to active state is controlled by a level-sensitive update strobe. While the strobe is low the latches are transparent, so the shadow contents reach the datapath as they change. While it is high the latches hold. An asynchronous reset clears every active enable.

Top module: `xbar_cfg`

## Requirements
- R1: When `ce_n_i` is 0 and `ser_par_n_i` is 0, every falling edge of `clk_i` shifts `sdi_i` into bit 0 of the 32-bit shadow chain. Each existing bit moves up one place.
- R2: When `ce_n_i` is 1, falling clock edges leave the shadow chain unchanged in both modes.
- R3: Output k is configured by chain bits [4k+3:4k]. Bit 4k+3 is the enable (1 = enabled) and bits [4k+2:4k] are the source index, most significant bit first. A frame therefore carries output 7's group first and output 0's group last, and within each group the enable comes first and select bit 0 comes last.
- R4: `sdo_o` always shows chain bit 31, which is the bit shifted in 32 serial edges earlier.
- R5: While `upd_n_i` is 1, the active configuration holds its value whatever happens to the shadow chain.
- R6: While `upd_n_i` is 0, the active configuration follows the shadow chain at once, including every intermediate state during shifting.
- R7: When `ce_n_i` is 0 and `ser_par_n_i` is 1, a falling edge writes `{par_en_i, par_sel_i}` into the group of output `par_addr_i`. All other groups stay unchanged.
- R8: While `rst_n_i` is 0, all active enables are 0: `out_idle_o` is all ones and `route_out_o` is all zeros. This holds even when `upd_n_i` is 0.
- R9: An output whose active enable is 0 drives 0 on `route_out_o` and 1 on `out_idle_o`, whatever its select bits or the inputs are.
- R10: An enabled output k drives `route_in_i[sel_k]` and shows 0 on its idle flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Programming clock; the shadow register loads on its falling edge |
| rst_n_i | input | 1 | Asynchronous active-low clear of the active enables |
| ce_n_i | input | 1 | Active-low chip enable for both load paths |
| ser_par_n_i | input | 1 | 0 selects serial shifting, 1 selects parallel single-entry write |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output (end of the chain) |
| upd_n_i | input | 1 | Active-low transparent update strobe |
| par_addr_i | input | 3 | Output index for a parallel write |
| par_sel_i | input | 3 | Source index for a parallel write |
| par_en_i | input | 1 | Enable bit for a parallel write |
| route_in_i | input | 8 | Input bits to be routed |
| route_out_o | output | 8 | Routed output bits |
| out_idle_o | output | 8 | Per-output disabled flag |

## Verification
Frames are loaded in five patterns: an identity map, a reversed map, all outputs broadcasting one input, all outputs disabled with nonzero selects, and a mixed frame. Each pattern is checked against two complementary input words, so a wrong select index, a swapped group, or reversed bit order inside a group produces a visible difference. Replaying the previous frame on the serial output confirms the chain length and its order. Parallel writes, writes gated off by chip enable, shifting with the strobe held low, and reset while the latches are transparent show that each path touches only the state it should.

// File: rtl/xbar_cfg.sv
module xbar_cfg #(
  parameter int N_OUT = 8,
  parameter int N_IN  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_n_i,
  input  logic                     ce_n_i,
  input  logic                     ser_par_n_i,
  input  logic                     sdi_i,
  output logic                     sdo_o,
  input  logic                     upd_n_i,
  input  logic [$clog2(N_OUT)-1:0] par_addr_i,
  input  logic [$clog2(N_IN)-1:0]  par_sel_i,
  input  logic                     par_en_i,
  input  logic [N_IN-1:0]          route_in_i,
  output logic [N_OUT-1:0]         route_out_o,
  output logic [N_OUT-1:0]         out_idle_o
);
  localparam int SW = $clog2(N_IN);
  localparam int AW = $clog2(N_OUT);
  localparam int G  = SW + 1;
  localparam int FW = N_OUT * G;

  logic [FW-1:0]       chain;
  logic [N_OUT-1:0]    sh_en;
  logic [N_OUT*SW-1:0] sh_sel;
  logic [N_OUT-1:0]    act_en;
  logic [N_OUT*SW-1:0] act_sel;

  always_ff @(negedge clk_i) begin
    if (!ce_n_i) begin
      if (!ser_par_n_i) begin
        chain <= {chain[FW-2:0], sdi_i};
      end else begin
        for (int k = 0; k < N_OUT; k++) begin
          if (par_addr_i == k[AW-1:0]) chain[k*G +: G] <= {par_en_i, par_sel_i};
        end
      end
    end
  end

  assign sdo_o = chain[FW-1];

  for (genvar k = 0; k < N_OUT; k++) begin : g_grp
    assign sh_en[k]             = chain[k*G + SW];
    assign sh_sel[k*SW +: SW]   = chain[k*G +: SW];
    assign route_out_o[k]       = act_en[k] & route_in_i[act_sel[k*SW +: SW]];
    assign out_idle_o[k]        = ~act_en[k];
  end

  always_latch begin
    if (!rst_n_i)     act_en = '0;
    else if (!upd_n_i) act_en = sh_en;
  end

  always_latch begin
    if (!upd_n_i) act_sel = sh_sel;
  end

  // R1
  shift_chk: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    (!ce_n_i && !ser_par_n_i) |=> (chain == {$past(chain[FW-2:0]), $past(sdi_i)}));

  // R2
  ce_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    ce_n_i |=> $stable(chain));

  // R7
  par_one_grp_chk: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    (!ce_n_i && ser_par_n_i) |=> ($countones(chain ^ $past(chain)) <= G));

  // R6
  transp_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !upd_n_i |-> (act_en == sh_en && act_sel == sh_sel));

  // R5
  upd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (upd_n_i && $past(upd_n_i)) |-> ($stable(act_en) && $stable(act_sel)));

  // R8
  rst_clear_chk: assert property (@(posedge clk_i)
    !rst_n_i |-> (out_idle_o == '1 && route_out_o == '0));
endmodule

// File: tb/xbar_cfg_bench.sv
module xbar_cfg_bench;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, ce_n = 1, ser_par_n = 0, sdi = 0, upd_n = 1, par_en = 0;
  logic [2:0] par_addr = 0, par_sel = 0;
  logic [7:0] din = 0, rout, idle;
  logic sdo;
  int n_chk = 0, n_err = 0;

  xbar_cfg u_xbar_cfg (
    .clk_i(clk), .rst_n_i(rst_n), .ce_n_i(ce_n), .ser_par_n_i(ser_par_n),
    .sdi_i(sdi), .sdo_o(sdo), .upd_n_i(upd_n), .par_addr_i(par_addr),
    .par_sel_i(par_sel), .par_en_i(par_en), .route_in_i(din),
    .route_out_o(rout), .out_idle_o(idle)
  );

  always #(CLK_P/2) clk = ~clk;

  localparam logic [39:0] VEC [5] = '{
    {32'hFEDCBA98, 8'hA5},
    {32'h89ABCDEF, 8'h3C},
    {32'hBBBBBBBB, 8'h08},
    {32'h75316420, 8'hFF},
    {32'hF0A38C51, 8'h6E}
  };

  function automatic logic [15:0] model(input logic [31:0] f, input logic [7:0] d);
    logic [7:0] o, id;
    for (int k = 0; k < 8; k++) begin
      logic [3:0] nb;
      nb = f[4*k +: 4];
      id[k] = ~nb[3];
      o[k]  = nb[3] ? d[nb[2:0]] : 1'b0;
    end
    return {id, o};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic shift_word(input logic [31:0] w, input logic ce_v, output logic [31:0] seen);
    seen = '0;
    for (int i = 31; i >= 0; i--) begin
      @(posedge clk); #1;
      seen = {seen[30:0], sdo};
      ce_n = ce_v; ser_par_n = 0; sdi = w[i];
      @(negedge clk);
    end
    @(posedge clk); #1;
    ce_n = 1;
  endtask

  task automatic pulse_upd;
    @(posedge clk); #1 upd_n = 0;
    @(posedge clk); #1 upd_n = 1;
  endtask

  task automatic par_write(input logic [2:0] a, input logic [2:0] s, input logic e, input logic ce_v);
    @(posedge clk); #1;
    ce_n = ce_v; ser_par_n = 1; par_addr = a; par_sel = s; par_en = e;
    @(negedge clk);
    @(posedge clk); #1;
    ce_n = 1; ser_par_n = 0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] act_f, sh, seen;
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    chk("R8 reset", {idle, rout}, 32'h0000FF00);
    rst_n = 1;
    act_f = 32'h0; sh = 32'h0;

    for (int i = 0; i < 5; i++) begin
      d = VEC[i][7:0];
      din = d;
      shift_word(VEC[i][39:8], 1'b0, seen);
      // R5 outputs hold while strobe is high
      chk("R5 hold during shift", {idle, rout}, model(act_f, d));
      // R4 previous frame emerges on serial output
      if (i > 0) chk("R4 chain output", seen, sh);
      sh = VEC[i][39:8];
      pulse_upd();
      // R1 R3 R10 frame decoded after update
      chk("R1 R3 R10 route", {idle, rout}, model(sh, d));
      din = ~d; #1;
      // R9 R10 complementary inputs
      chk("R9 R10 route inv", {idle, rout}, model(sh, ~d));
      act_f = sh;
    end

    // R2 gated shift
    shift_word(32'h12345678, 1'b1, seen);
    pulse_upd();
    chk("R2 ce high ignored", {idle, rout}, model(act_f, din));
    chk("R2 R4 sdo unchanged", {31'h0, sdo}, {31'h0, sh[31]});

    // R7 parallel writes
    par_write(3'd5, 3'd6, 1'b1, 1'b0);
    chk("R5 hold after par", {idle, rout}, model(act_f, din));
    pulse_upd();
    sh = 32'hF0E38C51;
    chk("R7 par write out5", {idle, rout}, model(sh, din));
    par_write(3'd0, 3'd2, 1'b0, 1'b0);
    par_write(3'd7, 3'd0, 1'b0, 1'b1);
    pulse_upd();
    sh = 32'hF0E38C52;
    chk("R7 R2 par write out0", {idle, rout}, model(sh, din));
    din = 8'h5A; #1;
    chk("R9 R10 par route", {idle, rout}, model(sh, din));

    // R6 transparent during shifting
    @(posedge clk); #1 upd_n = 0;
    for (int b = 0; b < 4; b++) begin
      logic bit_v;
      bit_v = (b != 1);
      @(posedge clk); #1;
      ce_n = 0; ser_par_n = 0; sdi = bit_v;
      @(negedge clk); #1;
      ce_n = 1;
      sh = {sh[30:0], bit_v};
      chk("R6 intermediate state", {idle, rout}, model(sh, din));
    end

    // R8 reset while latches transparent
    @(posedge clk); #1 rst_n = 0;
    @(posedge clk); @(posedge clk); #1;
    chk("R8 reset transparent", {idle, rout}, 32'h0000FF00);
    rst_n = 1; #1;
    chk("R6 R8 follow after reset", {idle, rout}, model(sh, din));
    upd_n = 1;
    chk("R4 sdo top bit", {31'h0, sdo}, {31'h0, sh[31]});

    finish_run();
  end
endmodule